// File: doc/BRIEF.md
# Synchronous Slave FIFO Port

This block sits on the device side of a parallel interface and holds four word-wide FIFOs that an external master reads and writes on one shared interface clock. The master picks a FIFO with a 2-bit select and drives active-low strobes for chip select, read, output enable, write and packet end. Data moves over a bidirectional 16-bit bus. The port drives an active-low empty flag and an active-low full flag for every FIFO. It also drives an end-of-packet indication for the word at the head of the selected FIFO.

Each FIFO prefetches its head word. Whatever sits at the read pointer is always ready, so turning on the output enable puts it on the bus at once. The read pointer moves only on a clock edge where chip select and the read strobe are both active. The following word then appears on the bus after that edge, so a burst read with both strobes held low delivers one word per clock. Writes capture the bus on every edge where chip select and the write strobe are active.

A packet-end strobe marks a word as the last word of a packet. If a write is accepted on the same edge, the word being written is marked. Otherwise the newest stored word is marked. The mark travels with the word and shows up when that word reaches the head.

Top module: `slave_fifo_port`

## Requirements
- R1: After reset every FIFO is empty: all `empty_n` bits are 0 and all `full_n` bits are 1.
- R2: On a rising edge with `cs_n`=0 and `wr_n`=0, the word on `data` is stored at the tail of the FIFO chosen by `fifo_sel`. Successive such edges store words in arrival order.
- R3: On a rising edge with `cs_n`=0, `rd_n`=0 and the chosen FIFO not empty, the head advances by one word. The next word is on `data` after that edge, so a held strobe gives one word per cycle.
- R4: `data` is driven with the head word of the chosen FIFO whenever `cs_n`=0 and `oe_n`=0, with no read strobe needed. The output enable never moves a pointer.
- R5: Read, write and packet-end strobes have no effect while `cs_n`=1.
- R6: A read of an empty FIFO is ignored. A write to a FIFO holding 512 words is ignored, and its contents are unchanged.
- R7: Bit i of `empty_n` is 1 when FIFO i held at least one word before the previous rising edge. Bit i of `full_n` is 0 when FIFO i held 512 words at that point. Both flags lag the occupancy change by one edge.
- R8: A packet-end strobe (`pkt_end_n`=0 with `cs_n`=0) with no accepted write marks the newest stored word of the chosen FIFO, if any. `eop` is 1 when the chosen FIFO is non-empty and its head word is marked.
- R9: A packet-end strobe on the same edge as an accepted write marks the word being written. A word written without the strobe is unmarked.
- R10: The four FIFOs are independent. Activity on one select value never changes the contents or flags of another FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_sel | input | 2 | Selects the FIFO addressed by the strobes and the bus |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable for the data bus, active low |
| wr_n | input | 1 | Write strobe, active low |
| pkt_end_n | input | 1 | Packet-end strobe, active low |
| data | inout | 16 | Bidirectional data bus |
| empty_n | output | 4 | Per-FIFO empty flag, active low |
| full_n | output | 4 | Per-FIFO full flag, active low |
| eop | output | 1 | Head word of the selected FIFO ends a packet |

## Verification
The hardest condition to reach is the full boundary. It takes 512 accepted writes to one FIFO before an extra write, and a write paired with a read, meet the blocked-write path. The stimulus streams a counting pattern into one FIFO until it fills. It then offers an extra word and drains the whole FIFO through a burst read, so any dropped, duplicated or overwritten word shows up as a data mismatch. Packet marks are placed both by a lone packet-end strobe and by one that coincides with a write. They are then read back through `eop` as each marked word reaches the head.

// File: rtl/slave_fifo_pkg.sv
package slave_fifo_pkg;

    // Per-FIFO request decoded from the shared strobes
    typedef struct packed {
        logic rd;
        logic wr;
        logic mark;
    } fifo_req_t;

endpackage

// File: rtl/slave_fifo_ctrl.sv
module slave_fifo_ctrl
    import slave_fifo_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fifo_req_t        req,
    output logic             rd_fire,
    output logic             wr_fire,
    output logic             mark_en,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] mark_ptr,
    output logic             not_empty,
    output logic             empty_n,
    output logic             full_n
);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [CNT_W-1:0] cnt;
        logic             empty_n;
        logic             full_n;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        rd_fire   = req.rd && (st_q.cnt != '0);
        wr_fire   = req.wr && (st_q.cnt != CNT_W'(DEPTH));
        // a mark with an accepted write travels with the write itself
        mark_en   = req.mark && !wr_fire && (st_q.cnt != '0);
        mark_ptr  = st_q.wr_ptr - PTR_W'(1);
        if (rd_fire) st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        if (wr_fire) st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
        st_d.cnt     = st_q.cnt + CNT_W'(wr_fire) - CNT_W'(rd_fire);
        // flags follow occupancy one edge later
        st_d.empty_n = (st_q.cnt != '0);
        st_d.full_n  = (st_q.cnt != CNT_W'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd_ptr  <= '0;
            st_q.wr_ptr  <= '0;
            st_q.cnt     <= '0;
            st_q.empty_n <= 1'b0;
            st_q.full_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr    = st_q.rd_ptr;
    assign wr_ptr    = st_q.wr_ptr;
    assign not_empty = (st_q.cnt != '0);
    assign empty_n   = st_q.empty_n;
    assign full_n    = st_q.full_n;

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(DEPTH) && req.wr && !req.rd) |=> $stable(st_q.wr_ptr));

    a_r6_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && req.rd && !req.wr) |=> (st_q.cnt == '0 && $stable(st_q.rd_ptr)));

    a_r3_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (st_q.rd_ptr == $past(st_q.rd_ptr) + PTR_W'(1)));

    a_r7_empty_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |=> !st_q.empty_n);

endmodule

// File: rtl/slave_fifo_store.sv
module slave_fifo_store #(
    parameter int NUM_FIFO = 4,
    parameter int DEPTH    = 512,
    parameter int DATA_W   = 16,
    localparam int SEL_W   = $clog2(NUM_FIFO),
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int WORDS   = NUM_FIFO * DEPTH
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_tag,
    input  logic              mark_en,
    input  logic [PTR_W-1:0]  mark_addr,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_tag
);

    logic [DATA_W-1:0] data_mem [WORDS];
    logic              tag_mem  [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[{sel, wr_addr}] <= wr_data;
            tag_mem[{sel, wr_addr}]  <= wr_tag;
        end
        if (mark_en) tag_mem[{sel, mark_addr}] <= 1'b1;
    end

    // prefetch: head word is always presented combinationally
    assign rd_data = data_mem[{sel, rd_addr}];
    assign rd_tag  = tag_mem[{sel, rd_addr}];

endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port
    import slave_fifo_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int DEPTH    = 512,
    parameter int DATA_W   = 16,
    localparam int SEL_W   = $clog2(NUM_FIFO),
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    fifo_sel,
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                oe_n,
    input  logic                wr_n,
    input  logic                pkt_end_n,
    inout  wire  [DATA_W-1:0]   data,
    output logic [NUM_FIFO-1:0] empty_n,
    output logic [NUM_FIFO-1:0] full_n,
    output logic                eop
);

    logic [NUM_FIFO-1:0] rd_fire, wr_fire, mark_en, not_empty;
    logic [PTR_W-1:0]    rd_ptr [NUM_FIFO];
    logic [PTR_W-1:0]    wr_ptr [NUM_FIFO];
    logic [PTR_W-1:0]    mk_ptr [NUM_FIFO];
    logic [DATA_W-1:0]   head_data;
    logic                head_tag;
    logic                drive_en;

    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
        fifo_req_t req;
        always_comb begin
            req.rd   = !cs_n && !rd_n      && (fifo_sel == SEL_W'(i));
            req.wr   = !cs_n && !wr_n      && (fifo_sel == SEL_W'(i));
            req.mark = !cs_n && !pkt_end_n && (fifo_sel == SEL_W'(i));
        end
        slave_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req),
            .rd_fire   (rd_fire[i]),
            .wr_fire   (wr_fire[i]),
            .mark_en   (mark_en[i]),
            .rd_ptr    (rd_ptr[i]),
            .wr_ptr    (wr_ptr[i]),
            .mark_ptr  (mk_ptr[i]),
            .not_empty (not_empty[i]),
            .empty_n   (empty_n[i]),
            .full_n    (full_n[i])
        );
    end

    slave_fifo_store #(.NUM_FIFO(NUM_FIFO), .DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
        .clk       (clk),
        .wr_en     (|wr_fire),
        .sel       (fifo_sel),
        .wr_addr   (wr_ptr[fifo_sel]),
        .wr_data   (data),
        .wr_tag    (!pkt_end_n),
        .mark_en   (|mark_en),
        .mark_addr (mk_ptr[fifo_sel]),
        .rd_addr   (rd_ptr[fifo_sel]),
        .rd_data   (head_data),
        .rd_tag    (head_tag)
    );

    assign drive_en = !cs_n && !oe_n;
    assign data     = drive_en ? head_data : 'z;
    assign eop      = not_empty[fifo_sel] && head_tag;

    // R10: only the addressed FIFO can accept a word on any edge
    a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_fire));

    a_r5_deselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (rd_fire == '0 && wr_fire == '0 && mark_en == '0));

endmodule

// File: tb/test_slave_fifo_port.sv
module test_slave_fifo_port;

    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fifo_sel = '0;
    logic        cs_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1, pkt_end_n = 1'b1;
    logic [15:0] tb_drv = '0;
    logic        tb_en = 1'b0;
    wire  [15:0] data;
    logic [3:0]  empty_n, full_n;
    logic        eop;

    assign data = tb_en ? tb_drv : 'z;

    always #10 clk = ~clk;   // 50 MHz

    slave_fifo_port i_slave_fifo_port (
        .clk(clk), .rst_n(rst_n), .fifo_sel(fifo_sel), .cs_n(cs_n), .rd_n(rd_n),
        .oe_n(oe_n), .wr_n(wr_n), .pkt_end_n(pkt_end_n), .data(data),
        .empty_n(empty_n), .full_n(full_n), .eop(eop)
    );

    // behavioural reference: one queue per FIFO, bit 16 = packet mark
    logic [16:0] mq [4][$];
    bit   exp_empty_n [4];
    bit   exp_full_n  [4];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int s = int'(fifo_sel);
        for (int i = 0; i < 4; i++) begin
            chk(empty_n[i] == exp_empty_n[i], "R7 empty flag", int'(empty_n[i]), int'(exp_empty_n[i]));
            chk(full_n[i] == exp_full_n[i], "R7 full flag", int'(full_n[i]), int'(exp_full_n[i]));
        end
        chk(eop == (mq[s].size() > 0 ? mq[s][0][16] : 1'b0), "R8 eop",
            int'(eop), (mq[s].size() > 0 ? int'(mq[s][0][16]) : 0));
        if (!cs_n && !oe_n && mq[s].size() > 0)
            chk(data == mq[s][0][15:0], req, int'(data), int'(mq[s][0][15:0]));
    endtask

    task automatic step(input int s, input bit cs, input bit rd, input bit oe,
                        input bit wr, input bit pe, input logic [15:0] din, input string req);
        bit rd_ok, wr_ok;
        fifo_sel = 2'(s);
        cs_n = !cs; rd_n = !rd; oe_n = !oe; wr_n = !wr; pkt_end_n = !pe;
        tb_drv = din; tb_en = wr;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            exp_empty_n[i] = (mq[i].size() != 0);
            exp_full_n[i]  = (mq[i].size() != DEPTH);
        end
        if (cs) begin
            rd_ok = rd && mq[s].size() > 0;
            wr_ok = wr && mq[s].size() < DEPTH;
            if (wr_ok) mq[s].push_back({pe, din});
            else if (pe && mq[s].size() > 0) mq[s][mq[s].size()-1][16] = 1'b1;
            if (rd_ok) void'(mq[s].pop_front());
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin exp_empty_n[i] = 0; exp_full_n[i] = 1; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(empty_n == 4'h0, "R1 empty_n", int'(empty_n), 0);
        chk(full_n == 4'hF, "R1 full_n", int'(full_n), 15);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: ordered writes into FIFO 0
        for (int k = 0; k < 5; k++) step(0, 1, 0, 0, 1, 0, 16'h1000 + 16'(k), "R2");
        step(0, 1, 0, 0, 0, 0, 0, "R2");
        // R4: output enable alone shows head word and does not advance
        for (int k = 0; k < 3; k++) step(0, 1, 0, 1, 0, 0, 0, "R4");
        // R3: burst read, one word per edge
        for (int k = 0; k < 3; k++) step(0, 1, 1, 1, 0, 0, 0, "R3");
        // R5: strobes with chip select high are ignored
        step(0, 0, 1, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 1, 16'hAAAA, "R5");
        step(0, 1, 0, 1, 0, 0, 0, "R5");
        step(0, 1, 0, 1, 0, 0, 0, "R5");

        // R6: read of empty FIFO 3 ignored
        step(3, 1, 1, 0, 0, 0, 0, "R6");
        step(3, 1, 0, 0, 1, 0, 16'hBEEF, "R6");
        step(3, 1, 0, 1, 0, 0, 0, "R6");
        // R10: FIFO 0 head unchanged by FIFO 3 traffic
        step(0, 1, 0, 1, 0, 0, 0, "R10");

        // R8/R9: packet marks on FIFO 1
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 1, 0, 16'h2000 + 16'(k), "R2");
        step(1, 1, 0, 0, 0, 1, 0, "R8");
        step(1, 1, 0, 0, 1, 0, 16'h2003, "R9");
        step(1, 1, 0, 0, 1, 1, 16'h2004, "R9");
        for (int k = 0; k < 6; k++) step(1, 1, 1, 1, 0, 0, 0, "R8");

        // R6: fill FIFO 2, extra write blocked
        for (int k = 0; k < DEPTH; k++) step(2, 1, 0, 0, 1, 0, 16'h4000 + 16'(k), "R2");
        step(2, 1, 0, 0, 1, 0, 16'hDEAD, "R6");
        step(2, 1, 1, 0, 1, 0, 16'hDEAD, "R6");
        step(2, 1, 0, 1, 0, 0, 0, "R7");
        for (int k = 0; k < DEPTH + 2; k++) step(2, 1, 1, 1, 0, 0, 0, "R6");

        // R3: simultaneous read and write on FIFO 0
        for (int k = 0; k < 4; k++) step(0, 1, 1, 0, 1, 0, 16'h3000 + 16'(k), "R3");
        for (int k = 0; k < 6; k++) step(0, 1, 1, 1, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, 0, "R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule